// File: doc/BRIEF.md
# QPSK Sampled Waveform Modulator

This block turns a serial bit stream into a sampled QPSK waveform. Incoming bits are paired into two-bit symbols. Each symbol selects one of four carrier phases. The block then emits that symbol as a fixed-length run of signed amplitude samples, one carrier cycle per symbol.

Each sample is built from two constant sinusoid tables, one for cosine and one for sine. The in-phase term and the quadrature term each carry a sign of +1 or -1 taken from the symbol. The block outputs their weighted difference. Both the bit input and the sample output use a valid/ready handshake, so the block can sit between a bit source and a converter that applies backpressure.

Top module: `qpsk_sample_mod`

## Requirements
- R1: Bits are paired in arrival order. The first bit of each pair is the symbol MSB and the second bit is the LSB.
- R2: Each symbol sets the signs of the two carrier components. The in-phase sign I is +1 when the LSB is 0 and -1 when the LSB is 1. The quadrature sign Q is +1 when MSB XOR LSB is 1 and -1 otherwise. This places symbol 10 at +45 degrees, 00 at -45 degrees, 01 at +135 degrees and 11 at -135 degrees.
- R3: Sample k of a symbol, with k counted from 0, equals I*C(k) - Q*S(k), given as a 16-bit two's complement value. C(k) and S(k) are 16384*cos(2*pi*k/100) and 16384*sin(2*pi*k/100), each rounded half away from zero.
- R4: Every symbol is exactly 100 output samples long, which is one whole carrier cycle. Sample 0 of every symbol is +16384 or -16384.
- R5: When samp_ready stays high and bits arrive fast enough, samp_valid stays high with no gap between successive symbols.
- R6: When no complete symbol is waiting, samp_valid falls only after the 100th sample of the current symbol has been accepted, never in the middle of a symbol.
- R7: While samp_valid is high and samp_ready is low, samp_valid stays high and samp_data holds its value. No sample is lost or repeated.
- R8: Reset is synchronous and active-high. It clears the sample index, any unpaired first bit and any buffered symbol. In the cycle after reset, samp_valid is 0 and bit_ready is 1.
- R9: A bit is taken on each clock edge where bit_valid and bit_ready are both high. The block holds one complete symbol ahead of the one being emitted, and bit_ready is low while that slot is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Serial bit present |
| bit_data | input | 1 | Serial bit value |
| bit_ready | output | 1 | Block can take a bit |
| samp_valid | output | 1 | Output sample present |
| samp_data | output | SAMP_W (16) | Signed waveform sample |
| samp_ready | input | 1 | Downstream takes the sample |

## Verification
The bench checks every sample of every symbol against I*C(k) - Q*S(k), computed from floating-point trigonometry in the bench, across several symbol sequences that cover all four symbols. A swapped bit order or a wrong phase assignment would show as sign errors on whole symbols. An off-by-one symbol length would shift every later sample.

It applies three backpressure patterns. With constant ready it counts idle output cycles, which exposes a generator that pauses at symbol boundaries. It also checks that samp_valid drops right after the last sample and not before, which catches early draining. Under stalls it checks that the held sample does not change.

It also sends one lone bit and then resets. A block that kept the unpaired half-symbol would misalign every symbol that follows.

// File: rtl/qpsk_mod_pkg.sv
package qpsk_mod_pkg;

  typedef logic [1:0] dibit_t;

  localparam real TWO_PI = 6.283185307179586;

  // Scaled, rounded (half away from zero) cos or sin of one table step
  function automatic int trig_q(input int k, input int n, input int shift, input bit want_sin);
    real ang;
    real v;
    ang = TWO_PI * real'(k) / real'(n);
    v   = (want_sin ? $sin(ang) : $cos(ang)) * (2.0 ** shift);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/qpsk_trig_rom.sv
module qpsk_trig_rom #(
  parameter int SAMP_W    = 16,
  parameter int SYM_LEN   = 100,
  parameter int AMP_SHIFT = 14,
  localparam int IDX_W    = $clog2(SYM_LEN)
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [SAMP_W-1:0] cos_val,
  output logic signed [SAMP_W-1:0] sin_val
);

  logic signed [SAMP_W-1:0] cos_tab [SYM_LEN];
  logic signed [SAMP_W-1:0] sin_tab [SYM_LEN];

  for (genvar g = 0; g < SYM_LEN; g++) begin : g_tab
    assign cos_tab[g] = SAMP_W'(qpsk_mod_pkg::trig_q(g, SYM_LEN, AMP_SHIFT, 1'b0));
    assign sin_tab[g] = SAMP_W'(qpsk_mod_pkg::trig_q(g, SYM_LEN, AMP_SHIFT, 1'b1));
  end

  assign cos_val = cos_tab[idx];
  assign sin_val = sin_tab[idx];

endmodule

// File: rtl/qpsk_dibit_pack.sv
module qpsk_dibit_pack
  import qpsk_mod_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_valid,
  input  logic   bit_data,
  output logic   bit_ready,
  output logic   dibit_vld,
  output dibit_t dibit,
  input  logic   dibit_take
);

  logic half_q;
  logic first_q;

  assign bit_ready = !dibit_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q    <= 1'b0;
      first_q   <= 1'b0;
      dibit_vld <= 1'b0;
      dibit     <= '0;
    end else begin
      if (dibit_take) dibit_vld <= 1'b0;
      if (bit_valid && bit_ready) begin
        if (half_q) begin
          dibit     <= {first_q, bit_data};
          dibit_vld <= 1'b1;
          half_q    <= 1'b0;
        end else begin
          first_q <= bit_data;
          half_q  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/qpsk_wave_gen.sv
module qpsk_wave_gen
  import qpsk_mod_pkg::*;
#(
  parameter int SAMP_W   = 16,
  parameter int SYM_LEN  = 100,
  localparam int IDX_W   = $clog2(SYM_LEN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dibit_vld,
  input  dibit_t                   dibit,
  output logic                     dibit_take,
  output logic [IDX_W-1:0]         idx,
  input  logic signed [SAMP_W-1:0] cos_val,
  input  logic signed [SAMP_W-1:0] sin_val,
  output logic                     samp_valid,
  output logic signed [SAMP_W-1:0] samp_data,
  input  logic                     samp_ready
);

  logic   act_q;
  dibit_t cur_q;
  logic   adv;
  logic   last;
  logic signed [SAMP_W:0] i_term;
  logic signed [SAMP_W:0] q_term;
  logic signed [SAMP_W:0] sum;

  assign adv        = !samp_valid || samp_ready;
  assign last       = (idx == IDX_W'(SYM_LEN - 1));
  assign dibit_take = dibit_vld && (!act_q || (adv && last));

  always_comb begin
    i_term = cur_q[0] ? -{cos_val[SAMP_W-1], cos_val} : {cos_val[SAMP_W-1], cos_val};
    q_term = (cur_q[1] ^ cur_q[0]) ? {sin_val[SAMP_W-1], sin_val} : -{sin_val[SAMP_W-1], sin_val};
    sum    = i_term - q_term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      act_q      <= 1'b0;
      cur_q      <= '0;
      samp_valid <= 1'b0;
      samp_data  <= '0;
    end else begin
      if (adv) begin
        samp_valid <= act_q;
        if (act_q) samp_data <= sum[SAMP_W-1:0];
      end
      if (act_q && adv) begin
        if (last) begin
          idx   <= '0;
          act_q <= dibit_vld;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (!act_q && dibit_vld) begin
        act_q <= 1'b1;
        idx   <= '0;
      end
      if (dibit_take) cur_q <= dibit;
    end
  end

endmodule

// File: rtl/qpsk_sample_mod.sv
module qpsk_sample_mod
  import qpsk_mod_pkg::*;
#(
  parameter int SAMP_W    = 16,
  parameter int SYM_LEN   = 100,
  parameter int AMP_SHIFT = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_valid,
  input  logic                     bit_data,
  output logic                     bit_ready,
  output logic                     samp_valid,
  output logic signed [SAMP_W-1:0] samp_data,
  input  logic                     samp_ready
);

  localparam int IDX_W = $clog2(SYM_LEN);

  logic                     dibit_vld;
  dibit_t                   dibit;
  logic                     dibit_take;
  logic [IDX_W-1:0]         idx;
  logic signed [SAMP_W-1:0] cos_val;
  logic signed [SAMP_W-1:0] sin_val;

  qpsk_dibit_pack u_pack (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_ready  (bit_ready),
    .dibit_vld  (dibit_vld),
    .dibit      (dibit),
    .dibit_take (dibit_take)
  );

  qpsk_trig_rom #(.SAMP_W(SAMP_W), .SYM_LEN(SYM_LEN), .AMP_SHIFT(AMP_SHIFT)) u_rom (
    .idx     (idx),
    .cos_val (cos_val),
    .sin_val (sin_val)
  );

  qpsk_wave_gen #(.SAMP_W(SAMP_W), .SYM_LEN(SYM_LEN)) u_gen (
    .clk        (clk),
    .rst        (rst),
    .dibit_vld  (dibit_vld),
    .dibit      (dibit),
    .dibit_take (dibit_take),
    .idx        (idx),
    .cos_val    (cos_val),
    .sin_val    (sin_val),
    .samp_valid (samp_valid),
    .samp_data  (samp_data),
    .samp_ready (samp_ready)
  );

endmodule

// File: rtl/qpsk_sample_mod_chk.sv
module qpsk_sample_mod_chk #(
  parameter int SAMP_W    = 16,
  parameter int SYM_LEN   = 100,
  parameter int AMP_SHIFT = 14
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bit_ready,
  input logic                     samp_valid,
  input logic signed [SAMP_W-1:0] samp_data,
  input logic                     samp_ready
);

  localparam int CNT_W = $clog2(SYM_LEN);
  localparam logic signed [SAMP_W-1:0] PEAK = SAMP_W'(1 << AMP_SHIFT);

  logic [CNT_W-1:0] seen_cnt;

  always_ff @(posedge clk) begin
    if (rst) seen_cnt <= '0;
    else if (samp_valid && samp_ready)
      seen_cnt <= (seen_cnt == CNT_W'(SYM_LEN - 1)) ? '0 : seen_cnt + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!samp_valid && bit_ready));  // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (samp_valid && !samp_ready) |=> (samp_valid && $stable(samp_data)));  // R7

  AST_DRAIN_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $fell(samp_valid) |-> (seen_cnt == '0));  // R6

  AST_SYMBOL_START: assert property (@(posedge clk) disable iff (rst)
    (samp_valid && seen_cnt == '0) |-> (samp_data == PEAK || samp_data == -PEAK));  // R4

endmodule

bind qpsk_sample_mod qpsk_sample_mod_chk #(
  .SAMP_W(SAMP_W), .SYM_LEN(SYM_LEN), .AMP_SHIFT(AMP_SHIFT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_ready  (bit_ready),
  .samp_valid (samp_valid),
  .samp_data  (samp_data),
  .samp_ready (samp_ready)
);

// File: tb/qpsk_sample_mod_tb_top.sv
`timescale 1ns/1ps
module qpsk_sample_mod_tb_top;

  localparam int N = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready;
  logic samp_valid;
  logic signed [15:0] samp_data;
  logic samp_ready = 1'b0;

  always #2.5 clk = ~clk;

  qpsk_sample_mod dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .samp_valid(samp_valid), .samp_data(samp_data),
    .samp_ready(samp_ready)
  );

  int n_checks = 0;
  int n_fail = 0;
  int exp_dib [32];
  int total = 0;
  int rcv = 0;
  int mode = 0;
  int cyc = 0;
  int gaps = 0;
  bit mon_on = 1'b0;
  bit just_done = 1'b0;
  bit prev_stall = 1'b0;
  logic signed [15:0] prev_data = '0;

  function automatic int rq(input int k, input bit s);
    real a, v;
    a = 6.283185307179586 * real'(k) / 100.0;
    v = (s ? $sin(a) : $cos(a)) * 16384.0;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // R2/R3: I from LSB, Q from MSB xor LSB
  function automatic int exp_sample(input int d, input int k);
    int i_s, q_s;
    i_s = (d & 1) ? -1 : 1;
    q_s = (((d >> 1) ^ d) & 1) ? 1 : -1;
    return i_s * rq(k, 1'b0) - q_s * rq(k, 1'b1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output monitor and ready driver, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    case (mode)
      0: samp_ready = 1'b1;
      1: samp_ready = (cyc % 3) != 2;
      default: samp_ready = (cyc % 7) < 2;
    endcase
    if (mon_on) begin
      if (just_done) begin
        chk(!samp_valid, "R6 valid drop after last sample", int'(samp_valid), 0);
        just_done = 1'b0;
      end
      if (prev_stall)
        chk(samp_valid && samp_data == prev_data, "R7 held sample",
            int'(samp_data), int'(prev_data));
      if (rcv > 0 && rcv < total && !samp_valid) gaps++;
      if (samp_valid && samp_ready && rcv < total) begin
        // R1 R3 R4: sample rcv%N of symbol rcv/N
        chk(int'(samp_data) == exp_sample(exp_dib[rcv / N], rcv % N), "R3 sample value",
            int'(samp_data), exp_sample(exp_dib[rcv / N], rcv % N));
        rcv++;
        if (rcv == total) just_done = 1'b1;
      end
      prev_stall = samp_valid && !samp_ready;
      prev_data  = samp_data;
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic run_phase(input int m, input int nd, input int seed);
    for (int i = 0; i < nd; i++) exp_dib[i] = (seed + i * 3 + i / 4) % 4;
    mode = m;
    rcv = 0;
    gaps = 0;
    total = nd * N;
    prev_stall = 1'b0;
    just_done = 1'b0;
    mon_on = 1'b1;
    for (int i = 0; i < nd; i++) begin
      send_bit(exp_dib[i][1]);  // R1 MSB first
      send_bit(exp_dib[i][0]);
    end
    wait (rcv == total);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    chk(!samp_valid && bit_ready, "R9 idle after drain", int'(samp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!samp_valid && bit_ready, "R8 reset state", int'(samp_valid), 0);

    run_phase(0, 12, 0);
    chk(gaps == 0, "R5 no gap between symbols", gaps, 0);
    chk(rcv == 12 * N, "R4 sample count", rcv, 12 * N);
    run_phase(1, 8, 1);
    run_phase(2, 8, 2);

    // R8: unpaired bit is discarded by reset
    send_bit(1'b1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!samp_valid && bit_ready, "R8 state after mid-pair reset", int'(samp_valid), 0);
    run_phase(0, 6, 3);
    chk(gaps == 0, "R5 no gap after reset", gaps, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", rcv, total);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule